// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

A purely combinational integer arithmetic and logic unit for the execute stage of a simple RISC integer pipeline. It takes two operands of equal width and a 4-bit operation code. It returns a result word, a carry flag and a signed overflow flag. Immediate operands are expected to be extended before they reach the unit. Multiply, divide and shift operations are handled elsewhere.

Internally the unit is a chain of identical one-bit slices. Each slice holds a full adder, a conditional inverter on the second operand and the per-bit logic functions. The least significant slice takes the subtract carry-in. Extra logic at the most significant slice produces carry, overflow and the comparison bit.

Top module: `int_alu`

## Requirements
- R1: Codes 0x0 (signed add) and 0x1 (unsigned add) return (A+B) mod 2^W. The carry flag equals the carry out of bit W-1.
- R2: Codes 0x2 (signed sub) and 0x3 (unsigned sub) return (A-B) mod 2^W, computed as A + ~B + 1. The carry flag is that adder's carry out of bit W-1, so it is 1 exactly when A >= B unsigned.
- R3: Under codes 0x0 and 0x2, the overflow flag is 1 exactly when the true signed result lies outside the W-bit two's-complement range.
- R4: Codes 0x1 and 0x3 never raise the overflow flag.
- R5: A signed add of two operands with different sign bits never raises overflow.
- R6: Code 0x4 returns A AND B, 0x5 returns A OR B, 0x6 returns A XOR B, and 0x7 returns NOT (A OR B). For all four codes both flags are 0.
- R7: Code 0xA returns 1 in bit 0 when A < B as signed numbers, and 0 otherwise. This holds even when A-B overflows. All other result bits and both flags are 0.
- R8: Code 0xB returns 1 in bit 0 when A < B as unsigned numbers, and 0 otherwise. All other result bits and both flags are 0.
- R9: Codes 0x8, 0x9 and 0xC to 0xF return a zero result with both flags 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First operand |
| opb | input | W | Second operand |
| op | input | 4 | Operation code |
| res | output | W | Result word |
| cout | output | 1 | Carry out of the top slice (arithmetic codes only) |
| ovf | output | 1 | Signed overflow (signed add/sub only) |

## Verification
The bench builds the unit with its default width of 32. At this width, the edges of the signed range (0x7FFFFFFF and 0x80000000) can be driven directly, along with all-ones operands. These values exercise overflow in both directions. They also cover the comparison cases in which the subtraction wraps. The directed edge values are then followed by random operands across all sixteen codes, so that every unused code is visited.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   op,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);
  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_ADDU = 4'h1;
  localparam logic [3:0] OP_SUB  = 4'h2;
  localparam logic [3:0] OP_SUBU = 4'h3;
  localparam logic [3:0] OP_AND  = 4'h4;
  localparam logic [3:0] OP_OR   = 4'h5;
  localparam logic [3:0] OP_XOR  = 4'h6;
  localparam logic [3:0] OP_NOR  = 4'h7;
  localparam logic [3:0] OP_SLT  = 4'hA;
  localparam logic [3:0] OP_SLTU = 4'hB;

  logic         inv_b, arith, signed_op;
  logic [W:0]   c;
  logic [W-1:0] sum, f_and, f_or, f_xor;
  logic         top_ovf, less;

  assign inv_b     = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  assign arith     = (op[3:2] == 2'b00);
  assign signed_op = (op == OP_ADD) || (op == OP_SUB);
  assign c[0]      = inv_b;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic bx;
    assign bx       = opb[i] ^ inv_b;
    assign sum[i]   = opa[i] ^ bx ^ c[i];
    assign c[i+1]   = (opa[i] & bx) | (c[i] & (opa[i] ^ bx));
    assign f_and[i] = opa[i] & opb[i];
    assign f_or[i]  = opa[i] | opb[i];
    assign f_xor[i] = opa[i] ^ opb[i];
  end

  assign top_ovf = c[W] ^ c[W-1];
  assign less    = (op == OP_SLT) ? (sum[W-1] ^ top_ovf) : ~c[W];

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: res = sum;
      OP_AND:                           res = f_and;
      OP_OR:                            res = f_or;
      OP_XOR:                           res = f_xor;
      OP_NOR:                           res = ~f_or;
      OP_SLT, OP_SLTU:                  res = {{(W-1){1'b0}}, less};
      default:                          res = '0;
    endcase
  end

  assign cout = arith & c[W];
  assign ovf  = signed_op & top_ovf;
endmodule

module int_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [3:0]   op,
  input logic [W-1:0] res,
  input logic         cout,
  input logic         ovf
);
  always_comb begin
    if (op == 4'h1 || op == 4'h3)
      a_r4_unsigned_no_ovf: assert (!ovf) else $error("unsigned op raised overflow");
    if (op == 4'h0 && (opa[W-1] != opb[W-1]))
      a_r5_mixed_sign_add: assert (!ovf) else $error("mixed-sign add overflowed");
    if (op == 4'h2 && (opa[W-1] == opb[W-1]))
      a_r3_same_sign_sub: assert (!ovf) else $error("same-sign sub overflowed");
    if (op[3:2] == 2'b01)
      a_r6_logic_flags: assert (!cout && !ovf) else $error("logic op set a flag");
    if (op == 4'hA || op == 4'hB)
      a_r7_slt_shape: assert (res[W-1:1] == '0 && !cout && !ovf) else $error("compare result malformed");
    if (op == 4'h8 || op == 4'h9 || op[3:2] == 2'b11)
      a_r9_unused_zero: assert (res == '0 && !cout && !ovf) else $error("unused code not zero");
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (.*);

// File: tb/int_alu_tb.sv
module int_alu_tb_top;
  localparam int W = 32;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ONE  = 1;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [W-1:0] opa = '0, opb = '0, res;
  logic [3:0]   op = '0;
  logic         cout, ovf;

  int_alu #(.W(W)) dut_i (.opa(opa), .opb(opb), .op(op), .res(res), .cout(cout), .ovf(ovf));

  typedef struct {
    logic [W-1:0] r;
    logic         c;
    logic         v;
    string        tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] m);
    exp_t e;
    logic [W:0] s;
    e.r = '0; e.c = 0; e.v = 0;
    case (m)
      4'h0, 4'h1: begin
        s = {1'b0, a} + {1'b0, b};
        e.r = s[W-1:0]; e.c = s[W];
        e.v = (m == 4'h0) && (a[W-1] == b[W-1]) && (e.r[W-1] != a[W-1]);
        e.tag = (m == 4'h0) ? "R1/R3/R5" : "R1/R4";
      end
      4'h2, 4'h3: begin
        e.r = a - b; e.c = (a >= b);
        e.v = (m == 4'h2) && (a[W-1] != b[W-1]) && (e.r[W-1] != a[W-1]);
        e.tag = (m == 4'h2) ? "R2/R3" : "R2/R4";
      end
      4'h4: begin e.r = a & b;    e.tag = "R6"; end
      4'h5: begin e.r = a | b;    e.tag = "R6"; end
      4'h6: begin e.r = a ^ b;    e.tag = "R6"; end
      4'h7: begin e.r = ~(a | b); e.tag = "R6"; end
      4'hA: begin e.r = ($signed(a) < $signed(b)) ? ONE : '0; e.tag = "R7"; end
      4'hB: begin e.r = (a < b) ? ONE : '0; e.tag = "R8"; end
      default: e.tag = "R9";
    endcase
    return e;
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] m);
    @(posedge clk); #1;
    opa = a; opb = b; op = m;
    q.push_back(model(a, b, m));
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (res !== e.r || cout !== e.c || ovf !== e.v) begin
        n_bad++;
        $display("FAIL %s op=%h a=%h b=%h: got res=%h c=%b v=%b, expected res=%h c=%b v=%b",
                 e.tag, op, opa, opb, res, cout, ovf, e.r, e.c, e.v);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    drive('0, '0, 4'h0);            // R1 idle/reset pattern
    drive(MAXP, ONE, 4'h0);         // R3 positive overflow
    drive(MINN, MINN, 4'h0);        // R3 negative overflow, carry
    drive(MAXP, MINN, 4'h0);        // R5 mixed signs
    drive(ONES, ONE, 4'h0);         // R5 -1+1, carry, no ovf
    drive(ONES, ONE, 4'h1);         // R1 R4 unsigned wrap
    drive(MAXP, ONE, 4'h1);         // R4 no ovf on unsigned
    drive(MINN, ONE, 4'h2);         // R3 sub overflow
    drive(MAXP, ONES, 4'h2);        // R3 sub overflow positive
    drive(MINN, ONE, 4'h3);         // R2 R4 unsigned sub
    drive(ONE, 32'd2, 4'h3);        // R2 borrow -> carry 0
    drive(32'd5, 32'd5, 4'h2);      // R2 equal -> carry 1
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'h4); // R6
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'h5);
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'h6);
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'h7);
    drive(MINN, ONE, 4'hA);         // R7 overflowing compare -> 1
    drive(MAXP, ONES, 4'hA);        // R7 overflowing compare -> 0
    drive(ONES, ONE, 4'hA);         // R7 -1 < 1
    drive(32'd3, 32'd3, 4'hA);      // R7 equal
    drive(ONES, ONE, 4'hB);         // R8 unsigned -> 0
    drive(ONE, ONES, 4'hB);         // R8 -> 1
    drive(ONES, ONES, 4'h8);        // R9
    drive(ONES, ONE, 4'h9);
    drive(ONES, ONES, 4'hC);
    drive(MINN, MAXP, 4'hF);
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] a, b;
      a = $urandom(); b = $urandom();
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) a = {a[W-1], {(W-1){~a[W-1]}}};
      drive(a, b, 4'(i % 16));
    end
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule